// File: doc/BRIEF.md
# ADC conversion queue sequencer

This block is the digital sequencing logic for a multi-channel analog-to-digital converter. Software fills a 64-word command table. A boundary value splits the table into two queues: queue 1 takes indices 0 up to boundary-1, and queue 2 takes indices boundary up to 63. Each command word names an input channel and a sample-time code, and it may carry a pause mark.

When a queue is triggered, the sequencer walks through its command words in index order. For each word it asks an external converter for one conversion over a start/done handshake. It stores the returned 10-bit value in a 64-entry result memory at the index of that command. A queue can be triggered by a software pulse, a rising edge on an external line or a free-running interval timer. Queue 1 also has a gated mode, in which it converts only while its external line is high. Queue 1 takes precedence over queue 2. Pause marks split a queue into sub-queues. Sticky pause and completion flags, and a pointer for each queue, show how far each queue has progressed. Results are read back through a registered port in one of three justification formats.

Top module: `adcq_seq`

## Requirements
- R1: After reset, `conv_start` is 0, all four flags are 0 and both queue pointers read 0.
- R2: A command word holds the pause mark in bit 9, the sample-time code in bits 8:7 and the channel in bits 5:0; bit 6 is ignored. A triggered queue converts its entries in ascending index order. It drives `conv_chan` and `conv_stime` from each word and keeps its pointer on the entry being converted. In single-scan mode, reaching the queue's last index sets that queue's done flag, returns the pointer to the queue's first index and stops the queue.
- R3: A command whose channel field is 63 ends the queue at that index, exactly as reaching the queue's last index does. That entry is never sent to the converter.
- R4: After the conversion of an entry with the pause mark completes, the queue stops, its pause flag sets and its pointer moves to the next index. The next trigger resumes the queue from that index.
- R5: In continuous-scan mode (`qN_cont`=1), a queue that reaches its end sets its done flag and restarts from its first index without a new trigger.
- R6: If queue 1 is triggered while a queue 2 conversion is in flight, that conversion completes first. Queue 1 then runs until it pauses or ends. Queue 2 then resumes at the entry after the one that was interrupted.
- R7: Source code 1 (external edge) starts a queue on a rising edge of its `ext_trig` bit only. Holding the line high does not start the queue again.
- R8: Source code 2 (timer) starts a queue on the internal interval tick. The tick occurs once every `timer_period`+1 clock cycles.
- R9: Source code 3 on queue 1 (gated) starts the queue on a rising edge of `ext_trig[0]` and lets it convert only while that line is high. If the line falls during a conversion, that conversion completes, the pointer advances and the queue stops.
- R10: The value on `rd_data` is set one cycle after `rd_addr` and `rd_fmt` are applied. For stored result r, `rd_fmt` 0 gives {6'b0,r}, 1 gives {r,6'b0}, 2 gives {~r[9],r[8:0],6'b0}, and 3 behaves as 0.
- R11: A trigger from a source the queue is not set to use has no effect. For example, a `sw_trig` pulse while the source is code 1 starts no conversion and leaves the pointer unchanged. Source code 0 means software.
- R12: Flags stay set until a `flag_clr` pulse clears them. Bit 0 clears pause1, bit 1 clears pause2, bit 2 clears done1 and bit 3 clears done2.
- R13: At most one conversion is in flight at a time. `conv_start`, `conv_chan` and `conv_stime` hold steady until `conv_done`, and `conv_start` is low in the cycle after `conv_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command table write enable |
| cmd_addr | input | 6 | Command table write index |
| cmd_wdata | input | 10 | Command word (bit 9 pause, 8:7 sample time, 5:0 channel) |
| boundary | input | 6 | First index of queue 2 |
| q1_src | input | 2 | Queue 1 trigger source: 0 software, 1 edge, 2 timer, 3 gated |
| q2_src | input | 2 | Queue 2 trigger source: 0 software, 1 edge, 2 timer, 3 none |
| q1_cont | input | 1 | Queue 1 continuous scan |
| q2_cont | input | 1 | Queue 2 continuous scan |
| timer_period | input | 16 | Interval timer reload value |
| sw_trig | input | 2 | Software trigger pulses, bit per queue |
| ext_trig | input | 2 | External trigger lines; bit 0 is also the queue 1 gate |
| conv_start | output | 1 | Conversion request, held until done |
| conv_chan | output | 6 | Channel to convert |
| conv_stime | output | 2 | Sample-time code |
| conv_done | input | 1 | Conversion finished, one-cycle pulse |
| conv_result | input | 10 | Conversion value, valid with conv_done |
| rd_addr | input | 6 | Result read index |
| rd_fmt | input | 2 | Read format select |
| rd_data | output | 16 | Formatted result, one cycle after address |
| pause_flag | output | 2 | Pause flags, bit per queue |
| done_flag | output | 2 | Queue-complete flags, bit per queue |
| flag_clr | input | 4 | Flag clear pulses |
| q1_ptr | output | 7 | Queue 1 current index |
| q2_ptr | output | 7 | Queue 2 current index |

## Verification
The assertions check the handshake rules on every cycle. The request and its channel and sample time stay steady until done, and the request drops after done. They also check that no end-of-queue code ever reaches the converter, that a queue 1 conversion never uses an index at or past the boundary, that pause flags stay set until cleared, and that completion is flagged only while the converter is idle. The bench scenarios are needed for the rest: the order of conversions across pauses and preemption, resuming at the right entry, the trigger sources and their ignored cases, the gate cutting off a queue, continuous restarts, and the three read formats.

// File: rtl/adcq_pkg.sv
package adcq_pkg;
  localparam logic [1:0] SRC_SW    = 2'd0;
  localparam logic [1:0] SRC_EDGE  = 2'd1;
  localparam logic [1:0] SRC_TIMER = 2'd2;
  localparam logic [1:0] SRC_GATE  = 2'd3;

  localparam logic [1:0] FMT_RJU = 2'd0;
  localparam logic [1:0] FMT_LJU = 2'd1;
  localparam logic [1:0] FMT_LJS = 2'd2;

  localparam int unsigned CHW = 6;

  typedef struct packed {
    logic           pause;
    logic [1:0]     stime;
    logic [CHW-1:0] chan;
  } cmd_t;
endpackage

// File: rtl/adcq_timer.sv
module adcq_timer #(
  parameter int unsigned TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] period,
  output logic          tick
);
  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = (cnt_q >= period);
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/adcq_trig.sv
module adcq_trig
  import adcq_pkg::*;
#(
  parameter bit GATE_OK = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] src,
  input  logic       sw,
  input  logic       ext,
  input  logic       tick,
  output logic       fire,
  output logic       allow
);
  logic ext_q;
  logic rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_q <= 1'b0;
    else        ext_q <= ext;
  end

  assign rise = ext & ~ext_q;

  generate
    if (GATE_OK) begin : g_gate
      always_comb begin
        fire  = 1'b0;
        allow = 1'b1;
        case (src)
          SRC_SW:    fire = sw;
          SRC_EDGE:  fire = rise;
          SRC_TIMER: fire = tick;
          default: begin
            fire  = rise;
            allow = ext;
          end
        endcase
      end
    end else begin : g_plain
      always_comb begin
        allow = 1'b1;
        case (src)
          SRC_SW:    fire = sw;
          SRC_EDGE:  fire = rise;
          SRC_TIMER: fire = tick;
          default:   fire = 1'b0;
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/adcq_res_ram.sv
module adcq_res_ram
  import adcq_pkg::*;
#(
  parameter int unsigned AW = 6,
  parameter int unsigned RW = 10,
  parameter int unsigned OW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [RW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  input  logic [1:0]    rfmt,
  output logic [OW-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << AW;
  localparam int unsigned PADW  = OW - RW;

  logic [RW-1:0] mem [DEPTH];
  logic [RW-1:0] rword;
  logic [OW-1:0] fmt_d;
  logic [OW-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rword = mem[raddr];

  always_comb begin
    case (rfmt)
      FMT_LJU: fmt_d = {rword, {PADW{1'b0}}};
      FMT_LJS: fmt_d = {~rword[RW-1], rword[RW-2:0], {PADW{1'b0}}};
      default: fmt_d = {{PADW{1'b0}}, rword};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= fmt_d;
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/adcq_seq.sv
module adcq_seq
  import adcq_pkg::*;
#(
  parameter int unsigned AW = 6,
  parameter int unsigned RW = 10,
  parameter int unsigned OW = 16,
  parameter int unsigned TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_we,
  input  logic [AW-1:0] cmd_addr,
  input  logic [9:0]    cmd_wdata,
  input  logic [AW-1:0] boundary,
  input  logic [1:0]    q1_src,
  input  logic [1:0]    q2_src,
  input  logic          q1_cont,
  input  logic          q2_cont,
  input  logic [TW-1:0] timer_period,
  input  logic [1:0]    sw_trig,
  input  logic [1:0]    ext_trig,
  output logic          conv_start,
  output logic [CHW-1:0] conv_chan,
  output logic [1:0]    conv_stime,
  input  logic          conv_done,
  input  logic [RW-1:0] conv_result,
  input  logic [AW-1:0] rd_addr,
  input  logic [1:0]    rd_fmt,
  output logic [OW-1:0] rd_data,
  output logic [1:0]    pause_flag,
  output logic [1:0]    done_flag,
  input  logic [3:0]    flag_clr,
  output logic [AW:0]   q1_ptr,
  output logic [AW:0]   q2_ptr
);
  localparam int unsigned DEPTH = 1 << AW;
  localparam logic [AW:0] PEND  = {1'b1, {AW{1'b0}}};
  localparam logic [CHW-1:0] EOQ_CH = '1;

  // command table
  cmd_t cmd_mem [DEPTH];
  logic unused_wbit;
  assign unused_wbit = cmd_wdata[6];

  always_ff @(posedge clk) begin
    if (cmd_we) cmd_mem[cmd_addr] <= cmd_t'({cmd_wdata[9:7], cmd_wdata[5:0]});
  end

  // trigger sources
  logic       tick;
  logic [1:0] fire, allow;
  logic [1:0][1:0] src_v;
  assign src_v = {q2_src, q1_src};

  adcq_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .period(timer_period), .tick(tick)
  );

  for (genvar g = 0; g < 2; g++) begin : g_q
    adcq_trig #(.GATE_OK(g == 0)) u_trig (
      .clk(clk), .rst_n(rst_n), .src(src_v[g]), .sw(sw_trig[g]),
      .ext(ext_trig[g]), .tick(tick), .fire(fire[g]), .allow(allow[g])
    );
  end

  // state
  logic [1:0][AW:0] ptr_q, ptr_d;
  logic [1:0]       run_q, run_d;
  logic [1:0]       pause_q, pause_d, done_q, done_d;
  logic             busy_q, busy_d;
  logic             cur_q_q, cur_q_d;
  logic [AW-1:0]    cur_idx_q, cur_idx_d;
  logic             cur_pause_q, cur_pause_d;
  logic [CHW-1:0]   chan_q, chan_d;
  logic [1:0]       stime_q, stime_d;
  logic             res_we;

  // queue selection
  logic [1:0][AW:0] q_start, q_end;
  logic [1:0]       eff_run, cont;
  logic             sel, any_run, at_end, is_eoq;
  logic [AW:0]      idx_sel;
  cmd_t             cmd_sel;

  assign q_start = {{1'b0, boundary}, {(AW+1){1'b0}}};
  assign q_end   = {PEND, {1'b0, boundary}};
  assign cont    = {q2_cont, q1_cont};
  assign eff_run = run_q & allow;
  assign any_run = |eff_run;
  assign sel     = ~eff_run[0];
  assign idx_sel = (ptr_q[sel] < q_start[sel]) ? q_start[sel] : ptr_q[sel];
  assign at_end  = (idx_sel >= q_end[sel]);
  assign cmd_sel = cmd_mem[idx_sel[AW-1:0]];
  assign is_eoq  = (cmd_sel.chan == EOQ_CH);

  always_comb begin
    ptr_d       = ptr_q;
    run_d       = run_q;
    pause_d     = pause_q & ~flag_clr[1:0];
    done_d      = done_q & ~flag_clr[3:2];
    busy_d      = busy_q;
    cur_q_d     = cur_q_q;
    cur_idx_d   = cur_idx_q;
    cur_pause_d = cur_pause_q;
    chan_d      = chan_q;
    stime_d     = stime_q;
    res_we      = 1'b0;
    if (busy_q) begin
      if (conv_done) begin
        busy_d          = 1'b0;
        res_we          = 1'b1;
        ptr_d[cur_q_q]  = {1'b0, cur_idx_q} + 1'b1;
        if (cur_pause_q) begin
          run_d[cur_q_q]   = 1'b0;
          pause_d[cur_q_q] = 1'b1;
        end
      end
    end else if (any_run) begin
      if (at_end || is_eoq) begin
        done_d[sel] = 1'b1;
        ptr_d[sel]  = q_start[sel];
        if (!cont[sel]) run_d[sel] = 1'b0;
      end else begin
        busy_d      = 1'b1;
        cur_q_d     = sel;
        cur_idx_d   = idx_sel[AW-1:0];
        cur_pause_d = cmd_sel.pause;
        chan_d      = cmd_sel.chan;
        stime_d     = cmd_sel.stime;
        ptr_d[sel]  = idx_sel;
      end
    end
    for (int i = 0; i < 2; i++) begin
      if (!allow[i])    run_d[i] = 1'b0;
      else if (fire[i]) run_d[i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q       <= '0;
      run_q       <= '0;
      pause_q     <= '0;
      done_q      <= '0;
      busy_q      <= 1'b0;
      cur_q_q     <= 1'b0;
      cur_idx_q   <= '0;
      cur_pause_q <= 1'b0;
      chan_q      <= '0;
      stime_q     <= '0;
    end else begin
      ptr_q       <= ptr_d;
      run_q       <= run_d;
      pause_q     <= pause_d;
      done_q      <= done_d;
      busy_q      <= busy_d;
      cur_q_q     <= cur_q_d;
      cur_idx_q   <= cur_idx_d;
      cur_pause_q <= cur_pause_d;
      chan_q      <= chan_d;
      stime_q     <= stime_d;
    end
  end

  adcq_res_ram #(.AW(AW), .RW(RW), .OW(OW)) u_res (
    .clk(clk), .rst_n(rst_n), .we(res_we), .waddr(cur_idx_q),
    .wdata(conv_result), .raddr(rd_addr), .rfmt(rd_fmt), .rdata(rd_data)
  );

  assign conv_start = busy_q;
  assign conv_chan  = chan_q;
  assign conv_stime = stime_q;
  assign pause_flag = pause_q;
  assign done_flag  = done_q;
  assign q1_ptr     = ptr_q[0];
  assign q2_ptr     = ptr_q[1];
endmodule

// File: rtl/adcq_seq_chk.sv
module adcq_seq_chk #(
  parameter int unsigned AW  = 6,
  parameter int unsigned CHW = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic           conv_start,
  input logic           conv_done,
  input logic [CHW-1:0] conv_chan,
  input logic [1:0]     conv_stime,
  input logic [1:0]     pause_flag,
  input logic [1:0]     done_flag,
  input logic [3:0]     flag_clr,
  input logic [AW:0]    q1_ptr,
  input logic [AW-1:0]  boundary,
  input logic           cur_q
);
  AST_START_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start && !conv_done |=> conv_start && $stable(conv_chan) && $stable(conv_stime)); // R13
  AST_DONE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start && conv_done |=> !conv_start); // R13
  AST_NO_EOQ_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> conv_chan != {CHW{1'b1}}); // R3
  AST_Q1_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start && !cur_q |-> q1_ptr < {1'b0, boundary}); // R2
  AST_PAUSE1_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    pause_flag[0] && !flag_clr[0] |=> pause_flag[0]); // R12
  AST_PAUSE2_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    pause_flag[1] && !flag_clr[1] |=> pause_flag[1]); // R12
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag[0]) |-> !conv_start); // R2
endmodule

bind adcq_seq adcq_seq_chk #(.AW(AW), .CHW(adcq_pkg::CHW)) u_chk (
  .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .conv_done(conv_done),
  .conv_chan(conv_chan), .conv_stime(conv_stime), .pause_flag(pause_flag),
  .done_flag(done_flag), .flag_clr(flag_clr), .q1_ptr(q1_ptr),
  .boundary(boundary), .cur_q(cur_q_q)
);

// File: tb/adcq_seq_bench.sv
module adcq_seq_bench;
  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_we;
  logic [5:0]  cmd_addr;
  logic [9:0]  cmd_wdata;
  logic [5:0]  boundary;
  logic [1:0]  q1_src, q2_src;
  logic        q1_cont, q2_cont;
  logic [15:0] timer_period;
  logic [1:0]  sw_trig, ext_trig;
  logic        conv_start;
  logic [5:0]  conv_chan;
  logic [1:0]  conv_stime;
  logic        conv_done = 1'b0;
  logic [9:0]  conv_result = '0;
  logic [5:0]  rd_addr;
  logic [1:0]  rd_fmt;
  logic [15:0] rd_data;
  logic [1:0]  pause_flag, done_flag;
  logic [3:0]  flag_clr;
  logic [6:0]  q1_ptr, q2_ptr;

  always #2 clk = ~clk;

  adcq_seq u_adcq_seq (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_addr(cmd_addr),
    .cmd_wdata(cmd_wdata), .boundary(boundary), .q1_src(q1_src), .q2_src(q2_src),
    .q1_cont(q1_cont), .q2_cont(q2_cont), .timer_period(timer_period),
    .sw_trig(sw_trig), .ext_trig(ext_trig), .conv_start(conv_start),
    .conv_chan(conv_chan), .conv_stime(conv_stime), .conv_done(conv_done),
    .conv_result(conv_result), .rd_addr(rd_addr), .rd_fmt(rd_fmt),
    .rd_data(rd_data), .pause_flag(pause_flag), .done_flag(done_flag),
    .flag_clr(flag_clr), .q1_ptr(q1_ptr), .q2_ptr(q2_ptr)
  );

  int total = 0;
  int bad   = 0;
  int nconv = 0;
  int exp_res [64];

  typedef struct { int q; int idx; int ch; int st; } exp_t;
  exp_t sbq [$];

  task automatic chk(input string req, input int act, input int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, expv);
    end
  endtask

  task automatic push(input int q, input int idx, input int ch, input int st);
    exp_t e;
    e.q = q; e.idx = idx; e.ch = ch; e.st = st;
    sbq.push_back(e);
  endtask

  // converter model and scoreboard monitor
  int cnt = LAT;
  always @(negedge clk) begin
    conv_done <= 1'b0;
    if (conv_start && !conv_done) begin
      if (cnt == 0) begin
        exp_t e;
        conv_done   <= 1'b1;
        conv_result <= {conv_chan, conv_stime, 2'b01};
        nconv++;
        if (sbq.size() == 0) begin
          chk("R2 R13 unexpected conversion chan", int'(conv_chan), -1);
        end else begin
          e = sbq.pop_front();
          chk("R2 R6 R13 order chan", int'(conv_chan), e.ch);
          chk("R2 R13 stime", int'(conv_stime), e.st);
          chk("R2 R6 pointer", (e.q == 1) ? int'(q1_ptr) : int'(q2_ptr), e.idx);
          exp_res[e.idx] = {e.ch[5:0], e.st[1:0], 2'b01};
        end
      end else begin
        cnt = cnt - 1;
      end
    end else begin
      cnt = LAT;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int idx, input bit p, input int st, input int ch);
    cmd_we = 1'b1; cmd_addr = idx[5:0];
    cmd_wdata = {p, st[1:0], 1'b0, ch[5:0]};
    cyc(1);
    cmd_we = 1'b0;
  endtask

  task automatic swp(input int q);
    sw_trig[q] = 1'b1; cyc(1); sw_trig[q] = 1'b0;
  endtask

  task automatic clr_all();
    flag_clr = 4'hF; cyc(1); flag_clr = 4'h0;
  endtask

  task automatic wait_done(input int q);
    int k = 0;
    while (!done_flag[q] && k < 2000) begin cyc(1); k++; end
  endtask

  task automatic wait_pause(input int q);
    int k = 0;
    while (!pause_flag[q] && k < 2000) begin cyc(1); k++; end
  endtask

  task automatic wait_start();
    int k = 0;
    while (!conv_start && k < 2000) begin cyc(1); k++; end
  endtask

  task automatic rd(input int idx, input int f, input string req);
    int r, e;
    rd_addr = idx[5:0]; rd_fmt = f[1:0];
    cyc(1);
    r = exp_res[idx];
    case (f)
      1: e = r << 6;
      2: e = (r ^ 512) << 6;
      default: e = r;
    endcase
    chk(req, int'(rd_data), e);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n0;
    rst_n = 1'b0; cmd_we = 1'b0; cmd_addr = '0; cmd_wdata = '0;
    boundary = 6'd4; q1_src = 2'd1; q2_src = 2'd0; q1_cont = 1'b0; q2_cont = 1'b0;
    timer_period = 16'd50; sw_trig = '0; ext_trig = '0; rd_addr = '0; rd_fmt = '0;
    flag_clr = '0;
    cyc(3);
    // R1 reset state
    chk("R1 conv_start", int'(conv_start), 0);
    chk("R1 flags", int'({pause_flag, done_flag}), 0);
    chk("R1 q1_ptr", int'(q1_ptr), 0);
    chk("R1 q2_ptr", int'(q2_ptr), 0);
    rst_n = 1'b1;
    cyc(1);
    wr(0, 0, 1, 5);  wr(1, 1, 2, 7);  wr(2, 0, 3, 9);  wr(3, 0, 0, 11);
    wr(4, 0, 0, 20); wr(5, 0, 1, 21); wr(6, 0, 2, 40); wr(7, 0, 0, 63);
    cmd_we = 1'b1; cmd_addr = 6'd8; cmd_wdata = 10'h040 | 10'd30; cyc(1); cmd_we = 1'b0;

    // R11: software pulse ignored while queue 1 uses edge source
    n0 = nconv;
    swp(0); cyc(20);
    chk("R11 no conversion", nconv - n0, 0);
    chk("R11 q1_ptr unchanged", int'(q1_ptr), 0);
    chk("R11 conv_start low", int'(conv_start), 0);

    // R2 R4: software trigger, pause splits queue 1
    q1_src = 2'd0;
    push(1, 0, 5, 1); push(1, 1, 7, 2);
    n0 = nconv;
    swp(0); wait_pause(0); cyc(2);
    chk("R4 pause1 set", int'(pause_flag[0]), 1);
    chk("R4 q1_ptr after pause", int'(q1_ptr), 2);
    chk("R4 conversions before pause", nconv - n0, 2);
    chk("R4 done1 not set", int'(done_flag[0]), 0);
    // R12 clear
    flag_clr = 4'b0001; cyc(1); flag_clr = 4'h0;
    chk("R12 pause1 cleared", int'(pause_flag[0]), 0);
    push(1, 2, 9, 3); push(1, 3, 11, 0);
    swp(0); wait_done(0); cyc(2);
    chk("R2 done1 set", int'(done_flag[0]), 1);
    chk("R2 q1_ptr back to start", int'(q1_ptr), 0);
    chk("R4 resumed entries", nconv - n0, 4);
    chk("R12 done1 holds", int'(done_flag[0]), 1);
    clr_all();

    // R3: queue 2 ends at channel-63 entry
    push(2, 4, 20, 0); push(2, 5, 21, 1); push(2, 6, 40, 2);
    n0 = nconv;
    swp(1); wait_done(1); cyc(10);
    chk("R3 done2 set", int'(done_flag[1]), 1);
    chk("R3 conversions", nconv - n0, 3);
    chk("R3 q2_ptr back to boundary", int'(q2_ptr), 4);
    clr_all();

    // R10 read formats
    rd(0, 0, "R10 right unsigned idx0");
    rd(0, 1, "R10 left unsigned idx0");
    rd(0, 2, "R10 left signed idx0");
    rd(6, 2, "R10 left signed idx6");
    rd(6, 3, "R10 code3 idx6");
    rd(3, 1, "R10 left unsigned idx3");

    // R6: queue 1 preempts queue 2 between conversions
    push(2, 4, 20, 0); push(1, 0, 5, 1); push(1, 1, 7, 2);
    push(2, 5, 21, 1); push(2, 6, 40, 2);
    n0 = nconv;
    swp(1); wait_start(); swp(0);
    wait_done(1); cyc(2);
    chk("R6 all conversions", nconv - n0, 5);
    chk("R6 pause1 set", int'(pause_flag[0]), 1);
    chk("R6 q1_ptr", int'(q1_ptr), 2);
    chk("R6 scoreboard empty", sbq.size(), 0);
    clr_all();

    // R7: edge source, held level does not retrigger
    q1_src = 2'd1;
    push(1, 2, 9, 3); push(1, 3, 11, 0);
    n0 = nconv;
    ext_trig[0] = 1'b1;
    wait_done(0); cyc(30);
    chk("R7 one scan", nconv - n0, 2);
    chk("R7 q1_ptr", int'(q1_ptr), 0);
    ext_trig[0] = 1'b0;
    clr_all();

    // R5: continuous scan restarts without a trigger
    q2_cont = 1'b1;
    for (int k = 0; k < 2; k++) begin
      push(2, 4, 20, 0); push(2, 5, 21, 1); push(2, 6, 40, 2);
    end
    n0 = nconv;
    swp(1); wait_done(1);
    q2_cont = 1'b0;
    flag_clr = 4'b1000; cyc(1); flag_clr = 4'h0;
    wait_done(1); cyc(30);
    chk("R5 two passes", nconv - n0, 6);
    chk("R5 done2 after second pass", int'(done_flag[1]), 1);
    clr_all();

    // R9: gated queue 1
    q1_src = 2'd3;
    push(1, 0, 5, 1);
    n0 = nconv;
    ext_trig[0] = 1'b1;
    wait_start();
    ext_trig[0] = 1'b0;
    cyc(20);
    chk("R9 in-flight conversion finished", nconv - n0, 1);
    chk("R9 q1_ptr after gate low", int'(q1_ptr), 1);
    chk("R9 stopped", int'(conv_start), 0);
    push(1, 1, 7, 2);
    ext_trig[0] = 1'b1;
    wait_pause(0); cyc(10);
    chk("R9 second gate conversions", nconv - n0, 2);
    chk("R9 q1_ptr after pause", int'(q1_ptr), 2);
    ext_trig[0] = 1'b0;
    clr_all();

    // R8: timer source
    q2_src = 2'd2;
    push(2, 4, 20, 0); push(2, 5, 21, 1); push(2, 6, 40, 2);
    n0 = nconv;
    wait_done(1);
    q2_src = 2'd0;
    cyc(60);
    chk("R8 timer scan done2", int'(done_flag[1]), 1);
    chk("R8 timer conversions", nconv - n0, 3);
    chk("R8 scoreboard empty", sbq.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule